// File: doc/BRIEF.md
# Periodic Tick Down-Counter Timer

This block is a 24-bit down-counter that produces a steady periodic tick. The tick can drive an operating system scheduler, or software can use it to measure delays. Software programs a period into a reload register, selects the count source and starts the counter. After that the counter runs on its own. When the count moves from one to zero, the block sets a sticky flag. If the interrupt is enabled, it also raises a one-cycle interrupt request. On the next counting step after zero, the counter reloads and continues downward, so a reload value of N gives one wrap every N+1 counting steps.

The counting step is either every core clock cycle or a single-cycle enable pulse on `ref_tick`. That pulse is an external reference that has already been synchronized into the core clock domain. Software reaches the block through a plain register port with valid, write, word address and data. Read data follows the address combinationally. A read of the control/status word clears the flag, so software can poll for wraps without using the interrupt. Polling is the reset default.

Top module: `tick_timer`

## Requirements
- R1: After reset the control/status, reload and current words read as zero and `irq` is low. The calibration word (address 3) reads as the `CAL_WORD` parameter.
- R2: While control bit 0 (enable) is clear, the current count keeps its value.
- R3: On each counting step with a nonzero count, the count decreases by exactly one.
- R4: On a counting step with a count of zero, the count takes the reload value (address 1). A reload value of N therefore gives one wrap every N+1 steps.
- R5: When control bit 2 is 1, every core clock cycle is a counting step. When control bit 2 is 0, only cycles with `ref_tick` high are counting steps.
- R6: When a counting step takes the count from 1 to 0, control/status bit 16 (the wrap flag) becomes 1. It stays 1 through later control writes.
- R7: A read of the control/status word (address 0) returns the flag and then clears it. If a wrap happens in the same cycle as the read, the flag stays set.
- R8: If control bit 1 is set, each wrap gives a single-cycle pulse on `irq` in the cycle after the wrap. If bit 1 is clear, `irq` stays low.
- R9: Any write to the current word (address 2) sets the count to zero and clears the flag, whatever the data written.
- R10: Writes to the calibration word have no effect on what it reads back.
- R11: Only bits 23:0 of a reload write are stored. Reading the reload word returns them zero-extended.
- R12: A control write stores bits 2:0 only. The flag is not writable, and all other control bits read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Register access strobe, one access per cycle |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 2 | Word address: 0 control/status, 1 reload, 2 current, 3 calibration |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| ref_tick | input | 1 | Synchronized single-cycle external reference pulse |
| irq | output | 1 | One-cycle interrupt request on each enabled wrap |

## Verification
The counter is driven through a table of reload values and counting spans. The spans stop just before, exactly at and just after a wrap, and one span covers several whole periods. This separates an off-by-one in the period from a missed reload or a late flag. The reload values include the smallest legal period and the full 24-bit value, which exposes truncation or a wrong zero compare. Directed runs then hold the counter with enable cleared and step it only with reference pulses. They also count interrupt pulses against polling mode, and read the flag twice to show it is sticky and then cleared. The remaining runs write to the current, calibration, reload and control words to confirm the clear, the read-only word and the field masks.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

    localparam int unsigned TT_CNT_W  = 24;
    localparam int unsigned TT_DATA_W = 32;

    typedef enum logic [1:0] {
        ADDR_CTRL    = 2'd0,
        ADDR_RELOAD  = 2'd1,
        ADDR_CURRENT = 2'd2,
        ADDR_CALIB   = 2'd3
    } tt_addr_e;

    // control/status bit positions
    localparam int unsigned CTL_ENABLE = 0;
    localparam int unsigned CTL_IRQEN  = 1;
    localparam int unsigned CTL_SRC    = 2;
    localparam int unsigned CTL_FLAG   = 16;

endpackage

// File: rtl/tick_timer_count.sv
module tick_timer_count #(
    parameter int unsigned CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             ld_reload_i,
    input  logic             clr_count_i,
    input  logic [CNT_W-1:0] wdata_i,
    output logic [CNT_W-1:0] count_o,
    output logic [CNT_W-1:0] reload_o,
    output logic             wrap_o
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic [CNT_W-1:0] reload;
    } cnt_state_t;

    cnt_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        wrap_o  = 1'b0;
        if (ld_reload_i) begin
            state_d.reload = wdata_i;
        end
        if (clr_count_i) begin
            state_d.count = '0;
        end else if (tick_i) begin
            if (state_q.count == '0) begin
                state_d.count = state_q.reload;
            end else begin
                state_d.count = state_q.count - ONE;
                wrap_o        = (state_q.count == ONE);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign count_o  = state_q.count;
    assign reload_o = state_q.reload;

    AST_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !clr_count_i && count_o != '0) |=> (count_o == $past(count_o) - ONE)); // R3

    AST_RELOAD_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !clr_count_i && count_o == '0) |=> (count_o == $past(reload_o))); // R4

    AST_CLEAR_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        clr_count_i |=> (count_o == '0)); // R9

endmodule

// File: rtl/tick_timer_csr.sv
module tick_timer_csr (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_ctrl_i,
    input  logic       rd_ctrl_i,
    input  logic       clr_flag_i,
    input  logic [2:0] ctrl_bits_i,
    input  logic       wrap_i,
    output logic       enable_o,
    output logic       irq_en_o,
    output logic       src_core_o,
    output logic       flag_o,
    output logic       irq_o
);

    typedef struct packed {
        logic enable;
        logic irq_en;
        logic src_core;
        logic flag;
        logic irq;
    } csr_state_t;

    csr_state_t state_d, state_q;

    always_comb begin
        state_d     = state_q;
        state_d.irq = wrap_i && state_q.irq_en;
        if (wr_ctrl_i) begin
            state_d.enable   = ctrl_bits_i[0];
            state_d.irq_en   = ctrl_bits_i[1];
            state_d.src_core = ctrl_bits_i[2];
        end
        // a wrap in the same cycle wins over a clearing read
        if (wrap_i) begin
            state_d.flag = 1'b1;
        end else if (rd_ctrl_i || clr_flag_i) begin
            state_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign enable_o   = state_q.enable;
    assign irq_en_o   = state_q.irq_en;
    assign src_core_o = state_q.src_core;
    assign flag_o     = state_q.flag;
    assign irq_o      = state_q.irq;

    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_i |=> flag_o); // R6

    AST_FLAG_READ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ctrl_i && !wrap_i) |=> !flag_o); // R7

    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o); // R8

    AST_IRQ_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> flag_o); // R8

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_i && !irq_en_o) |=> !irq_o); // R8

endmodule

// File: rtl/tick_timer.sv
module tick_timer
    import tick_timer_pkg::*;
#(
    parameter int unsigned CNT_W    = TT_CNT_W,
    parameter int unsigned DATA_W   = TT_DATA_W,
    parameter logic [31:0] CAL_WORD = 32'h0000_2710
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              ref_tick,
    output logic              irq
);

    tt_addr_e         addr;
    logic             wr_ctrl, rd_ctrl, wr_reload, wr_current;
    logic             enable, irq_en, src_core, flag, wrap, tick;
    logic [CNT_W-1:0] count, reload;
    logic             unused_wdata_bits;

    assign addr       = tt_addr_e'(bus_addr);
    assign wr_ctrl    = bus_valid &&  bus_write && (addr == ADDR_CTRL);
    assign rd_ctrl    = bus_valid && !bus_write && (addr == ADDR_CTRL);
    assign wr_reload  = bus_valid &&  bus_write && (addr == ADDR_RELOAD);
    assign wr_current = bus_valid &&  bus_write && (addr == ADDR_CURRENT);

    assign tick = enable && (src_core || ref_tick);

    assign unused_wdata_bits = ^bus_wdata[DATA_W-1:CNT_W];

    tick_timer_count #(.CNT_W(CNT_W)) u_count (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick),
        .ld_reload_i (wr_reload),
        .clr_count_i (wr_current),
        .wdata_i     (bus_wdata[CNT_W-1:0]),
        .count_o     (count),
        .reload_o    (reload),
        .wrap_o      (wrap)
    );

    tick_timer_csr u_csr (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_ctrl_i   (wr_ctrl),
        .rd_ctrl_i   (rd_ctrl),
        .clr_flag_i  (wr_current),
        .ctrl_bits_i (bus_wdata[2:0]),
        .wrap_i      (wrap),
        .enable_o    (enable),
        .irq_en_o    (irq_en),
        .src_core_o  (src_core),
        .flag_o      (flag),
        .irq_o       (irq)
    );

    always_comb begin
        bus_rdata = '0;
        case (addr)
            ADDR_CTRL: begin
                bus_rdata[CTL_ENABLE] = enable;
                bus_rdata[CTL_IRQEN]  = irq_en;
                bus_rdata[CTL_SRC]    = src_core;
                bus_rdata[CTL_FLAG]   = flag;
            end
            ADDR_RELOAD:  bus_rdata[CNT_W-1:0] = reload;
            ADDR_CURRENT: bus_rdata[CNT_W-1:0] = count;
            default:      bus_rdata = DATA_W'(CAL_WORD);
        endcase
    end

    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && !wr_current) |=> $stable(count)); // R2

    AST_REF_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !src_core && !ref_tick && !wr_current) |=> $stable(count)); // R5

endmodule

// File: tb/sim_tick_timer.sv
module sim_tick_timer;

    localparam logic [31:0] CAL = 32'h0000_2710;
    localparam int NV = 9;
    // {reload[24], counting steps[16], expected count[24], expected flag[8]}
    localparam logic [71:0] VECS [0:NV-1] = '{
        {24'd5,        16'd1,  24'd5,        8'd0},
        {24'd5,        16'd3,  24'd3,        8'd0},
        {24'd5,        16'd5,  24'd1,        8'd1},
        {24'd5,        16'd6,  24'd0,        8'd1},
        {24'd5,        16'd7,  24'd5,        8'd1},
        {24'd1,        16'd4,  24'd0,        8'd1},
        {24'd100,      16'd50, 24'd51,       8'd0},
        {24'hFFFFFF,   16'd3,  24'hFFFFFD,   8'd0},
        {24'd3,        16'd9,  24'd3,        8'd1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        ref_tick = 1'b0;
    logic        irq;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    tick_timer #(.CAL_WORD(CAL)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ref_tick(ref_tick), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // every task starts and ends at a falling edge, one rising edge inside
    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic arm(input logic [23:0] rl, input logic [31:0] ctl);
        wr(2'd0, 32'd0);
        wr(2'd1, {8'd0, rl});
        wr(2'd2, 32'd0);
        wr(2'd0, ctl);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int          irq_seen;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 irq", {31'd0, irq}, 32'd0);
        rd(2'd0, d); check("R1 ctrl", d, 32'd0);
        rd(2'd1, d); check("R1 reload", d, 32'd0);
        rd(2'd2, d); check("R1 current", d, 32'd0);
        rd(2'd3, d); check("R1 calib", d, CAL);

        // table: core clock source, polling mode (R3 R4 R6 R8)
        for (int v = 0; v < NV; v++) begin
            logic [23:0] rl;
            logic [15:0] k;
            logic [23:0] ec;
            logic [7:0]  ef;
            {rl, k, ec, ef} = VECS[v];
            arm(rl, 32'h5);
            irq_seen = 0;
            for (int j = 0; j < int'(k); j++) begin
                @(negedge clk);
                if (irq) irq_seen++;
            end
            rd(2'd2, d); check($sformatf("R3/R4 count v%0d", v), d, {8'd0, ec});
            rd(2'd0, d); check($sformatf("R6 flag v%0d", v), d, {15'd0, ef[0], 16'h0005});
            check($sformatf("R8 polling no irq v%0d", v), irq_seen, 0);
        end

        // R2 hold while disabled
        arm(24'd10, 32'h5);
        idle(3);
        wr(2'd0, 32'h4);
        idle(5);
        rd(2'd2, d); check("R2 hold", d, 32'd7);

        // R5 reference pulses only
        arm(24'd10, 32'h1);
        idle(5);
        rd(2'd2, d); check("R5 no pulses", d, 32'd0);
        repeat (3) begin
            ref_tick = 1'b1; @(negedge clk);
            ref_tick = 1'b0; @(negedge clk);
        end
        rd(2'd2, d); check("R5 three pulses", d, 32'd8);

        // R8 interrupt pulses, period 3 with reload 2
        arm(24'd2, 32'h7);
        for (int j = 1; j <= 12; j++) begin
            @(negedge clk);
            check($sformatf("R8 irq step %0d", j), {31'd0, irq}, (j % 3 == 0) ? 32'd1 : 32'd0);
        end

        // R6 sticky flag, R7 read clears it
        arm(24'd1, 32'h5);
        idle(4);
        wr(2'd0, 32'h0);
        rd(2'd0, d); check("R6 sticky", d, 32'h0001_0000);
        rd(2'd0, d); check("R7 read clear", d, 32'd0);

        // R9 write to current value
        wr(2'd0, 32'h5);
        idle(1);
        wr(2'd0, 32'h0);
        wr(2'd2, 32'h0000_0123);
        rd(2'd2, d); check("R9 count cleared", d, 32'd0);
        rd(2'd0, d); check("R9 flag cleared", d, 32'd0);

        // R10 calibration read-only
        wr(2'd3, 32'hDEAD_BEEF);
        rd(2'd3, d); check("R10 calib", d, CAL);

        // R11 reload field width
        wr(2'd1, 32'hFFFF_FFFF);
        rd(2'd1, d); check("R11 reload mask", d, 32'h00FF_FFFF);

        // R12 control field mask
        wr(2'd0, 32'hFFFF_FFFF);
        rd(2'd0, d); check("R12 ctrl mask", d, 32'h0000_0007);
        wr(2'd0, 32'h0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule